// File: doc/BRIEF.md
# Scrambled-Address Register Bus Wrapper

This block sits between a simple valid/ready register bus and an inner byte-wide register file. It decodes a 17-bit byte address. Addresses with bit 16 set reach two wrapper control registers. Addresses with bit 16 clear reach the inner register space. While address scrambling is active, a fixed 16-bit bit permutation maps each bus address onto the inner address it reaches.

Two write-only key registers control the wrapper. One of them opens or closes read access to the inner space. The other switches the permutation on or off. Inner writes are posted: the most recent write waits in a one-entry buffer until the next inner access commits it. Writing the "scrambling on" key discards a write that is still waiting, so software performs a dummy read first. In this block the inner register file is modelled as a plain byte RAM of 2^MEM_AW entries, indexed by the low bits of the inner address.

Top module: `srw_wrapper`

## Requirements
- R1: After reset, reads of the inner space are locked, scrambling is active, `resp_ready` is 0 and `resp_rdata` is 0.
- R2: A request with `req_addr[16]`=1 addresses the wrapper registers, using `req_addr[15:0]` as the offset. A request with `req_addr[16]`=0 addresses the inner space. A read of 0x10000+X returns 0 even when inner location X holds data.
- R3: A write of 0x54524545 to offset 0x10010 unlocks inner reads. A write of 0x57415452 to the same offset locks them again.
- R4: A write of 0x42494E47 to offset 0x10014 turns scrambling off, so the inner address equals `req_addr[15:0]`. A write of 0x00000000 to the same offset turns scrambling on. Any other value leaves the setting unchanged.
- R5: While scrambling is active, bus address bit k goes to inner bit 2k for k in 1..7, bus bit k goes to inner bit 31-2k for k in 8..15, and bit 0 stays in place. Bus address 0x4043 therefore reaches inner 0x100D.
- R6: A locked read of the inner space returns 0 and does not commit a pending write.
- R7: Both wrapper registers read as 0. A write of any value other than the keys listed in R3 and R4 leaves the lock and scrambling state unchanged.
- R8: Only byte accesses (`req_byte`=1) reach the inner space. A non-byte inner write is discarded and commits nothing. A non-byte inner read returns 0.
- R9: An inner byte write is held in a one-entry posted buffer. It is committed by the next inner byte write or by the next unlocked inner byte read. A read of the pending location returns the pending data.
- R10: A write of 0x00000000 to offset 0x10014 discards any pending inner write. A write committed earlier by a dummy read is kept.
- R11: A request is accepted when `req_valid`=1 and `resp_ready`=0. `resp_ready` is high for exactly the one cycle after acceptance, and `resp_rdata` holds the read result in that cycle. `resp_rdata` is 0 for writes and for every read not covered by R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present; held until `resp_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = wider access |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 32 | Write data; inner writes use bits 7:0 |
| resp_ready | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Read data, valid while `resp_ready` is 1 |

## Verification
Every result is due in the first cycle after the rising edge that accepts the request. Read data, the `resp_ready` pulse, and any change in lock state, scrambling or the posted buffer all appear there. The next request therefore already sees the new state. The bench drives each request at a falling edge and compares the pulse and the data at the following falling edge against a behavioural model, which is updated at the moment of acceptance. In every other cycle the bench checks that `resp_ready` stays low, so a late, early or repeated pulse is caught in the cycle it occurs.

// File: rtl/srw_pkg.sv
// Package: shared widths, wrapper offsets, key values and the address
// permutation rule for the scrambled-address register wrapper.
// Assumes a 17-bit byte address whose top bit selects the wrapper window.
package srw_pkg;
    localparam int BUS_AW = 17;
    localparam int IN_AW  = 16;
    localparam int DW     = 32;
    localparam int BYTE_W = 8;

    localparam logic [IN_AW-1:0] OFF_RDGATE = 16'h0010;
    localparam logic [IN_AW-1:0] OFF_SCRAM  = 16'h0014;

    localparam logic [DW-1:0] KEY_RD_OPEN   = 32'h5452_4545;
    localparam logic [DW-1:0] KEY_RD_CLOSE  = 32'h5741_5452;
    localparam logic [DW-1:0] KEY_SCRAM_OFF = 32'h4249_4E47;
    localparam logic [DW-1:0] KEY_SCRAM_ON  = 32'h0000_0000;

    // Inner bit index that bus address bit k lands on while scrambling.
    function automatic int scram_dst(input int k, input int aw);
        if (k < aw / 2)
            return 2 * k;
        else
            return 2 * aw - 1 - 2 * k;
    endfunction
endpackage

// File: rtl/srw_addr_perm.sv
// Module: srw_addr_perm
// Maps a bus address onto the inner address. When en is set, each bus bit
// moves to the position given by srw_pkg::scram_dst; otherwise the address
// passes through unchanged. Purely combinational.
module srw_addr_perm
    import srw_pkg::*;
#(
    parameter int AW = IN_AW
) (
    input  logic          en,
    input  logic [AW-1:0] bus_addr,
    output logic [AW-1:0] inner_addr
);
    logic [AW-1:0] swz;

    // One wire per bit: bus bit k drives its permuted inner position.
    for (genvar k = 0; k < AW; k++) begin : g_bit
        assign swz[scram_dst(k, AW)] = bus_addr[k];
    end

    // Select permuted or straight address.
    assign inner_addr = en ? swz : bus_addr;

    // Known-point check of the mapping on the default width.
    if (AW == 16) begin : g_chk
        always_comb begin
            if (en && bus_addr == AW'(16'h4043))
                p_known_point_r5: assert (inner_addr == AW'(16'h100D))
                    else $error("R5 permutation known point");
        end
    end
endmodule

// File: rtl/srw_ctrl.sv
// Module: srw_ctrl
// Holds the two wrapper control bits: read gate and scrambling enable.
// Only full-word key values change them; all else is ignored. Writing the
// scrambling-on key also requests a discard of the pending inner write.
// Assumes wr_stb is a single-cycle strobe for one accepted wrapper write.
module srw_ctrl
    import srw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [IN_AW-1:0] offset,
    input  logic [DW-1:0]    wdata,
    output logic             rd_open,
    output logic             scram_on,
    output logic             drop_pend
);
    logic hit_gate, hit_scram;

    // Decode which control register a write addresses.
    always_comb begin
        hit_gate  = wr_stb && (offset == OFF_RDGATE);
        hit_scram = wr_stb && (offset == OFF_SCRAM);
        drop_pend = hit_scram && (wdata == KEY_SCRAM_ON);
    end

    // Read gate: opens and closes only on its two keys.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_open <= 1'b0;
        else if (hit_gate && wdata == KEY_RD_OPEN)
            rd_open <= 1'b1;
        else if (hit_gate && wdata == KEY_RD_CLOSE)
            rd_open <= 1'b0;
    end

    // Scrambling enable: on from reset, toggled only by its two keys.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scram_on <= 1'b1;
        else if (hit_scram && wdata == KEY_SCRAM_OFF)
            scram_on <= 1'b0;
        else if (hit_scram && wdata == KEY_SCRAM_ON)
            scram_on <= 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!rd_open && scram_on));
    p_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && offset == OFF_RDGATE && wdata == KEY_RD_OPEN) |=> rd_open);
    p_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && offset == OFF_RDGATE && wdata == KEY_RD_CLOSE) |=> !rd_open);
    p_scram_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && offset == OFF_SCRAM && wdata == KEY_SCRAM_OFF) |=> !scram_on);
    p_gate_nonkey_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_stb && offset == OFF_RDGATE &&
           (wdata == KEY_RD_OPEN || wdata == KEY_RD_CLOSE))) |=> $stable(rd_open));
    p_scram_nonkey_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_stb && offset == OFF_SCRAM &&
           (wdata == KEY_SCRAM_OFF || wdata == KEY_SCRAM_ON))) |=> $stable(scram_on));
endmodule

// File: rtl/srw_store.sv
// Module: srw_store
// Inner register model: a byte RAM behind a one-entry posted-write buffer.
// A write parks in the buffer and commits the previous entry; a read
// commits the entry and forwards it on an address match. drop clears the
// buffer without committing. Assumes wr_stb, rd_stb and drop are mutually
// exclusive single-cycle strobes. The RAM has no reset.
module srw_store
    import srw_pkg::*;
#(
    parameter int MEM_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              drop,
    input  logic [IN_AW-1:0]  addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic              pend_v;
    logic [MEM_AW-1:0] pend_a;
    logic [BYTE_W-1:0] pend_d;
    logic [MEM_AW-1:0] idx;
    logic              commit;
    logic              unused_hi;

    // Index RAM by the low inner address bits; upper bits alias.
    assign idx       = addr[MEM_AW-1:0];
    assign unused_hi = ^addr[IN_AW-1:MEM_AW];

    // Commit on any inner access while an entry waits.
    assign commit = (wr_stb || rd_stb) && pend_v;

    // Read path with forwarding from the pending entry.
    assign rdata = (pend_v && pend_a == idx) ? pend_d : mem[idx];

    // RAM write port, fed only from the posted buffer.
    always_ff @(posedge clk) begin
        if (commit)
            mem[pend_a] <= pend_d;
    end

    // Posted buffer: load on write, clear on drop, clear after a read commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0;
            pend_a <= '0;
            pend_d <= '0;
        end else if (drop) begin
            pend_v <= 1'b0;
        end else if (wr_stb) begin
            pend_v <= 1'b1;
            pend_a <= idx;
            pend_d <= wdata;
        end else if (rd_stb) begin
            pend_v <= 1'b0;
        end
    end

    p_strobes_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_stb, rd_stb, drop}) <= 1);
    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (pend_v && pend_a == $past(idx) && pend_d == $past(wdata)));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_v && !wr_stb && !rd_stb && !drop) |=> (pend_v && $stable(pend_d)));
    p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !pend_v);
endmodule

// File: rtl/srw_wrapper.sv
// Module: srw_wrapper (top)
// Register bus front end: accepts one request at a time, splits the
// 17-bit address into wrapper and inner windows, applies the optional
// address permutation, gates inner reads and returns a one-cycle response.
// Assumes the requester holds req_valid and its fields until resp_ready.
module srw_wrapper
    import srw_pkg::*;
#(
    parameter int MEM_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_byte,
    input  logic [BUS_AW-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              resp_ready,
    output logic [DW-1:0]     resp_rdata
);
    logic              accept, to_wrap, inner_ok;
    logic              st_wr, st_rd, ctl_wr;
    logic              rd_open, scram_on, drop_pend;
    logic [IN_AW-1:0]  inner_addr;
    logic [BYTE_W-1:0] st_rdata;

    // Request decode: window select, size filter and read gate.
    always_comb begin
        accept   = req_valid && !resp_ready;
        to_wrap  = req_addr[BUS_AW-1];
        inner_ok = !to_wrap && req_byte;
        st_wr    = accept && req_write && inner_ok;
        st_rd    = accept && !req_write && inner_ok && rd_open;
        ctl_wr   = accept && req_write && to_wrap;
    end

    srw_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (ctl_wr),
        .offset    (req_addr[IN_AW-1:0]),
        .wdata     (req_wdata),
        .rd_open   (rd_open),
        .scram_on  (scram_on),
        .drop_pend (drop_pend)
    );

    srw_addr_perm #(.AW(IN_AW)) u_perm (
        .en         (scram_on),
        .bus_addr   (req_addr[IN_AW-1:0]),
        .inner_addr (inner_addr)
    );

    srw_store #(.MEM_AW(MEM_AW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (st_wr),
        .rd_stb (st_rd),
        .drop   (drop_pend),
        .addr   (inner_addr),
        .wdata  (req_wdata[BYTE_W-1:0]),
        .rdata  (st_rdata)
    );

    // Response register: one-cycle pulse and zero-filled read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_ready <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_ready <= accept;
            resp_rdata <= st_rd ? {{(DW-BYTE_W){1'b0}}, st_rdata} : '0;
        end
    end

    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ready |=> !resp_ready);
    p_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ready |-> $past(req_valid));
    p_idle_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_ready |-> (resp_rdata == '0));
    p_locked_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_ready && $past(!req_write && !req_addr[BUS_AW-1] && !rd_open))
        |-> (resp_rdata == '0));
    p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_ready && $past(req_addr[BUS_AW-1])) |-> (resp_rdata == '0));
    p_wide_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_ready && $past(!req_byte)) |-> (resp_rdata == '0));
endmodule

// File: tb/srw_wrapper_test.sv
// Bench for srw_wrapper: behavioural model (associative byte memory,
// one-entry pending slot, two flags) checked on every falling edge.
module srw_wrapper_test;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_AW     = 12;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_byte  = 1'b1;
    logic [16:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_ready;
    logic [31:0] resp_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic expect_rdy = 1'b0;
    logic mon_en = 1'b0;

    // Model state
    byte unsigned m_mem [int];
    bit           m_open = 0;
    bit           m_scram = 1;
    bit           m_pv = 0;
    int           m_pa = 0;
    byte unsigned m_pd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    srw_wrapper #(.MEM_AW(MEM_AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_ready(resp_ready), .resp_rdata(resp_rdata)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Inner address to bus address while scrambling.
    function automatic logic [15:0] to_bus(input logic [15:0] a);
        logic [15:0] b;
        for (int j = 0; j < 16; j++) b[j] = (j < 8) ? a[2*j] : a[31-2*j];
        return b;
    endfunction

    // Bus address to inner address while scrambling.
    function automatic logic [15:0] from_bus(input logic [15:0] b);
        logic [15:0] a;
        for (int j = 0; j < 16; j++) begin
            if (j < 8) a[2*j] = b[j];
            else       a[31-2*j] = b[j];
        end
        return a;
    endfunction

    // Per-cycle monitor on the completion pulse.
    always @(negedge clk) begin
        if (mon_en) check("R11 ready timing", {31'b0, resp_ready}, {31'b0, expect_rdy});
    end

    // Model update at acceptance; returns expected read data.
    function automatic logic [31:0] model(input bit wr, input bit byt,
                                          input logic [16:0] ad, input logic [31:0] wd);
        int ia;
        logic [31:0] r = '0;
        ia = int'((m_scram ? from_bus(ad[15:0]) : ad[15:0])) & ((1 << MEM_AW) - 1);
        if (ad[16]) begin
            if (wr && ad[15:0] == 16'h0010) begin
                if (wd == 32'h54524545) m_open = 1;
                if (wd == 32'h57415452) m_open = 0;
            end
            if (wr && ad[15:0] == 16'h0014) begin
                if (wd == 32'h42494E47) m_scram = 0;
                if (wd == 32'h0) begin m_scram = 1; m_pv = 0; end
            end
        end else if (byt) begin
            if (wr) begin
                if (m_pv) m_mem[m_pa] = m_pd;
                m_pv = 1; m_pa = ia; m_pd = wd[7:0];
            end else if (m_open) begin
                if (m_pv) m_mem[m_pa] = m_pd;
                m_pv = 0;
                r = m_mem.exists(ia) ? {24'b0, m_mem[ia]} : 32'h0;
            end
        end
        return r;
    endfunction

    task automatic xfer(input string rq, input bit wr, input bit byt,
                        input logic [16:0] ad, input logic [31:0] wd);
        logic [31:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_byte = byt; req_addr = ad; req_wdata = wd;
        exp = model(wr, byt, ad, wd);
        @(posedge clk);
        expect_rdy = 1'b1;
        @(negedge clk);
        #1;
        check(rq, resp_rdata, exp);
        req_valid = 1'b0;
        expect_rdy = 1'b0;
    endtask

    task automatic wr8(input string rq, input logic [16:0] ad, input logic [7:0] d);
        xfer(rq, 1'b1, 1'b1, ad, {24'b0, d});
    endtask
    task automatic rd8(input string rq, input logic [16:0] ad);
        xfer(rq, 1'b0, 1'b1, ad, 32'h0);
    endtask
    task automatic wreg(input string rq, input logic [15:0] off, input logic [31:0] d);
        xfer(rq, 1'b1, 1'b1, {1'b1, off}, d);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset ready", {31'b0, resp_ready}, 32'h0);
        check("R1 reset rdata", resp_rdata, 32'h0);
        mon_en = 1'b1;

        // Locked after reset; read of pending location returns 0
        wr8("R9 post write", 17'h00005, 8'hA5);
        rd8("R6 locked read zero (R1)", 17'h00005);
        wreg("R3 unlock", 16'h0010, 32'h54524545);
        rd8("R9 forward pending after locked read", 17'h00005);
        rd8("R7 gate reg reads zero", 17'h10010);
        rd8("R7 scram reg reads zero", 17'h10014);
        wreg("R7 non-key to gate", 16'h0010, 32'h12345678);
        rd8("R7 still unlocked", 17'h00005);
        wreg("R3 lock", 16'h0010, 32'h57415452);
        rd8("R3 locked read zero", 17'h00005);
        wreg("R3 unlock again", 16'h0010, 32'h54524545);
        rd8("R2 wrapper window read zero", 17'h10005);

        // Size filter
        xfer("R8 wide write", 1'b1, 1'b0, 17'h00005, 32'hFFFFFFFF);
        rd8("R8 wide write ignored", 17'h00005);
        xfer("R8 wide read zero", 1'b0, 1'b0, 17'h00005, 32'h0);

        // Permutation known point
        wreg("R4 scramble off", 16'h0014, 32'h42494E47);
        wr8("R4 straight write", 17'h0100D, 8'h3C);
        wr8("R4 straight write 2", 17'h00043, 8'h77);
        rd8("R4 straight read", 17'h00043);
        wreg("R4 scramble on", 16'h0014, 32'h0);
        rd8("R5 bus 4043 reaches 100D", 17'h04043);
        check("R5 model known point", {16'b0, to_bus(16'h100D)}, 32'h4043);
        wreg("R4 non-key to scram reg", 16'h0014, 32'hDEADBEEF);
        rd8("R4 scramble still on", 17'h04043);

        // Round trip of the reference mapping
        lf = 16'hACE1;
        for (int i = 0; i < 8; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            check("R5 round trip", {16'b0, to_bus(from_bus(lf))}, {16'b0, lf});
        end

        // Straight write, scrambled read across many addresses
        for (int i = 0; i < 24; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            wreg("R4 off", 16'h0014, 32'h42494E47);
            wr8("R5 write straight", {1'b0, lf}, lf[7:0] ^ 8'h5A);
            rd8("R5 commit straight", {1'b0, lf});
            wreg("R4 on", 16'h0014, 32'h0);
            rd8("R5 scrambled read", {1'b0, to_bus(lf)});
        end

        // Dropped posted write
        wr8("R10 base write", 17'h00100, 8'h11);
        rd8("R10 base commit", 17'h00100);
        wr8("R10 pending write", 17'h00100, 8'h22);
        wreg("R10 scramble on drops", 16'h0014, 32'h0);
        rd8("R10 dropped write lost", 17'h00100);
        wr8("R10 pending write 2", 17'h00100, 8'h22);
        rd8("R10 dummy read", 17'h00100);
        wreg("R10 scramble on after dummy", 16'h0014, 32'h0);
        rd8("R10 committed write kept", 17'h00100);

        // Write commits previous write
        wr8("R9 write a", 17'h00200, 8'h01);
        wr8("R9 write b", 17'h00300, 8'h02);
        rd8("R9 read a", 17'h00200);
        rd8("R9 read b", 17'h00300);

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule